// File: doc/BRIEF.md
# Host-to-PCI Window Address Translator

This block sits between a host load/store port and a PCI master. Each request carries a 34-bit host address, a write flag, write data and a size code for dense requests. The top five address bits choose one of several host windows. The block then turns the request into a PCI address, a command class, byte enables and write data placed on the correct byte lanes. The result is presented one clock after the request.

Four windows use a left-shifted sparse encoding: sparse memory, I/O, interrupt-acknowledge/special cycle, and configuration. In these windows the PCI address is the window offset shifted right by five. The low offset bits carry the transfer size, and the two lowest PCI address bits pick the byte lane. Sparse memory reaches the full 32-bit PCI space through a writable extension register, which supplies PCI bits [31:27]. Dense memory passes the offset straight through and accepts only aligned longword requests.

Read data returned by the PCI side on `bus_rdata` is shifted down to the lane of the request currently presented and masked to its size. Requests that hit no window, or that have an illegal size or alignment, raise the error flag and issue no access.

Top module: `hpx_xlate`

## Requirements
- R1: Window select uses host address bits [33:29]. Values 24..31 select dense memory (command 3). Values 16..23 select sparse memory (command 2). Value 13 selects interrupt-acknowledge (command 4), value 14 selects I/O (command 1), and value 15 selects configuration (command 5). Value 12 selects the extension register. When no access is issued, the command output is 0.
- R2: In the I/O, interrupt-acknowledge and configuration windows, the PCI address is the 29-bit window offset shifted right by five. Only 24 significant bits result, and PCI bits [31:24] are zero.
- R3: In sparse-encoded windows, offset bits [4:3] give the size: 00 is a byte, 01 is a 16-bit word, and 11 is a 32-bit longword. Code 10 raises the error flag.
- R4: The lane is PCI address bits [1:0], which are offset bits [6:5]. Byte enables are 0001, 0011 or 1111 shifted left by the lane. A request whose bytes would pass lane 3 raises the error flag: a word at lane 3, or a longword at any lane other than 0.
- R5: For writes, `pci_wdata` is the write data masked to the size and shifted left by 8 times the lane. For reads, `pci_wdata` is zero.
- R6: In the cycle a read access is presented, `host_rdata` is `bus_rdata` shifted right by 8 times that access's lane and masked to its size.
- R7: A write to the extension window stores the write data ANDed with 0xF8000000; the register resets to 0. A sparse memory access takes its PCI bits [31:27] from the register. This includes an access issued in the very next cycle after the register write. A read of the extension window issues no access and raises no error.
- R8: In the dense window, the PCI address equals host bits [31:0] and the byte enables are 1111. The request must have size code 2 (longword) and address bits [1:0] equal to 00; any other request raises the error flag.
- R9: A host address in no window (bits [33:29] below 12) raises the error flag and issues no access.
- R10: Outputs are registered one cycle after `req_valid`, and `pci_valid` and `pci_err` are never both high. After reset, or after a cycle with no request, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 34 | Host physical address |
| req_dsize | input | 2 | Size code for dense requests (2 = longword) |
| req_wdata | input | 32 | Host write data, right-justified |
| bus_rdata | input | 32 | Raw longword returned by the PCI side |
| pci_valid | output | 1 | A PCI access is issued this cycle |
| pci_err | output | 1 | The previous request was rejected |
| pci_cmd | output | 3 | Command class of the issued access |
| pci_addr | output | 32 | PCI byte address |
| pci_be | output | 4 | Byte enables |
| pci_wdata | output | 32 | Lane-placed write data |
| host_rdata | output | 32 | Lane-extracted, size-masked read data |

## Verification
An extension register update and the translation of the next sparse access land on the same clock edge. The register loads at that edge, and the following request is translated from the register's output. The bench provokes this by issuing a register write and, in the very next cycle, a sparse memory read. It also issues random requests where register writes and sparse accesses are freely interleaved. Its behavioural model updates its own copy of the register at the moment of the write. Every sparse address presented is compared against that copy, so a design that still used the old value would fail the upper-bit comparison.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_IO   = 3'd1,
    WIN_SMEM = 3'd2,
    WIN_DMEM = 3'd3,
    WIN_IACK = 3'd4,
    WIN_CONF = 3'd5,
    WIN_HAE  = 3'd6
  } win_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_LONG = 2'b11
  } xsz_e;

  function automatic logic [2:0] sz_bytes(xsz_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      SZ_LONG: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // legal size and all bytes inside one longword
  function automatic logic lane_fits(xsz_e s, logic [1:0] lane);
    return (s != SZ_RSVD) && (({1'b0, lane} + sz_bytes(s)) <= 3'd4);
  endfunction

  function automatic logic [3:0] lane_be(xsz_e s, logic [1:0] lane);
    logic [3:0] m;
    case (s)
      SZ_BYTE: m = 4'b0001;
      SZ_WORD: m = 4'b0011;
      SZ_LONG: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m << lane;
  endfunction

  function automatic logic [31:0] size_mask(xsz_e s);
    case (s)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_WORD: return 32'h0000_FFFF;
      SZ_LONG: return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] lane_place(logic [31:0] d, xsz_e s, logic [1:0] lane);
    return (d & size_mask(s)) << {lane, 3'b000};
  endfunction

  function automatic logic [31:0] lane_pick(logic [31:0] d, xsz_e s, logic [1:0] lane);
    return (d >> {lane, 3'b000}) & size_mask(s);
  endfunction

endpackage

// File: rtl/hpx_win_decode.sv
module hpx_win_decode
  import hpx_pkg::*;
(
  input  logic [4:0] sel,
  output win_e       win,
  output logic       miss
);
  always_comb begin
    win  = WIN_NONE;
    miss = 1'b0;
    case (sel[4:3])
      2'b11: win = WIN_DMEM;
      2'b10: win = WIN_SMEM;
      2'b01: begin
        if (sel[2]) begin
          case (sel[1:0])
            2'b00:   win = WIN_HAE;
            2'b01:   win = WIN_IACK;
            2'b10:   win = WIN_IO;
            default: win = WIN_CONF;
          endcase
        end else begin
          miss = 1'b1;
        end
      end
      default: miss = 1'b1;
    endcase
  end
endmodule

// File: rtl/hpx_hae_reg.sv
module hpx_hae_reg #(
  parameter int PW = 32,
  parameter int SH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [PW-1:0] hae_q
);
  localparam logic [PW-1:0] KEEP = {{SH{1'b1}}, {(PW-SH){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hae_q <= '0;
    else if (wr_en) hae_q <= PW'(wdata) & KEEP;
  end
endmodule

// File: rtl/hpx_fmt.sv
module hpx_fmt
  import hpx_pkg::*;
#(
  parameter int PW   = 32,
  parameter int SH   = 5,
  parameter int IO_W = 24
) (
  input  win_e          win,
  input  logic [PW-1:0] addr,
  input  logic [1:0]    dsize,
  input  logic          wr,
  input  logic [31:0]   wdata,
  input  logic [PW-1:0] hae,
  output logic [PW-1:0] paddr,
  output logic [3:0]    be,
  output logic [31:0]   wlane,
  output logic [1:0]    lane,
  output xsz_e          size,
  output logic          bad
);
  always_comb begin
    paddr = '0;
    lane  = addr[SH+1:SH];
    size  = xsz_e'(addr[SH-1:SH-2]);
    bad   = 1'b0;
    case (win)
      WIN_SMEM: begin
        paddr = hae | PW'(addr[PW-1:SH]);
        bad   = !lane_fits(size, lane);
      end
      WIN_IO, WIN_IACK, WIN_CONF: begin
        paddr = PW'(addr[IO_W+SH-1:SH]);
        bad   = !lane_fits(size, lane);
      end
      WIN_DMEM: begin
        paddr = addr;
        lane  = 2'd0;
        size  = SZ_LONG;
        bad   = (dsize != 2'd2) || (addr[1:0] != 2'b00);
      end
      default: begin
        lane = 2'd0;
        size = SZ_BYTE;
      end
    endcase
    be    = lane_be(size, lane);
    wlane = wr ? lane_place(wdata, size, lane) : 32'h0;
  end
endmodule

// File: rtl/hpx_rd_align.sv
module hpx_rd_align
  import hpx_pkg::*;
(
  input  logic [31:0] raw,
  input  logic [1:0]  lane,
  input  xsz_e        size,
  output logic [31:0] data
);
  assign data = lane_pick(raw, size, lane);
endmodule

// File: rtl/hpx_xlate.sv
module hpx_xlate
  import hpx_pkg::*;
#(
  parameter int HA_W = 34,
  parameter int PW   = 32,
  parameter int SH   = 5,
  parameter int IO_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [HA_W-1:0] req_addr,
  input  logic [1:0]      req_dsize,
  input  logic [31:0]     req_wdata,
  input  logic [31:0]     bus_rdata,
  output logic            pci_valid,
  output logic            pci_err,
  output logic [2:0]      pci_cmd,
  output logic [PW-1:0]   pci_addr,
  output logic [3:0]      pci_be,
  output logic [31:0]     pci_wdata,
  output logic [31:0]     host_rdata
);
  localparam int SEL_W = HA_W - PW + 3;

  win_e          win;
  logic          win_miss;
  logic          hae_wr;
  logic [PW-1:0] hae_q;
  logic [PW-1:0] f_addr;
  logic [3:0]    f_be;
  logic [31:0]   f_wd;
  logic [1:0]    f_lane;
  xsz_e          f_size;
  logic          f_bad;
  logic          acc_ok;
  logic          rej;

  win_e          r_cmd;
  logic [1:0]    r_lane;
  xsz_e          r_size;

  hpx_win_decode u_dec (
    .sel  (req_addr[HA_W-1:HA_W-SEL_W]),
    .win  (win),
    .miss (win_miss)
  );

  assign hae_wr = req_valid && req_write && (win == WIN_HAE);

  hpx_hae_reg #(.PW(PW), .SH(SH)) u_hae (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (hae_wr),
    .wdata (req_wdata),
    .hae_q (hae_q)
  );

  hpx_fmt #(.PW(PW), .SH(SH), .IO_W(IO_W)) u_fmt (
    .win   (win),
    .addr  (req_addr[PW-1:0]),
    .dsize (req_dsize),
    .wr    (req_write),
    .wdata (req_wdata),
    .hae   (hae_q),
    .paddr (f_addr),
    .be    (f_be),
    .wlane (f_wd),
    .lane  (f_lane),
    .size  (f_size),
    .bad   (f_bad)
  );

  assign acc_ok = req_valid && !win_miss && (win != WIN_HAE) && !f_bad;
  assign rej    = req_valid && (win_miss || ((win != WIN_HAE) && f_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_valid <= 1'b0;
      pci_err   <= 1'b0;
      r_cmd     <= WIN_NONE;
      pci_addr  <= '0;
      pci_be    <= '0;
      pci_wdata <= '0;
      r_lane    <= '0;
      r_size    <= SZ_BYTE;
    end else begin
      pci_valid <= acc_ok;
      pci_err   <= rej;
      r_cmd     <= acc_ok ? win : WIN_NONE;
      pci_addr  <= f_addr;
      pci_be    <= f_be;
      pci_wdata <= f_wd;
      r_lane    <= f_lane;
      r_size    <= f_size;
    end
  end

  assign pci_cmd = r_cmd;

  hpx_rd_align u_rd (
    .raw  (bus_rdata),
    .lane (r_lane),
    .size (r_size),
    .data (host_rdata)
  );
endmodule

// File: rtl/hpx_xlate_chk.sv
module hpx_xlate_chk
  import hpx_pkg::*;
#(
  parameter int PW = 32,
  parameter int SH = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [31:0]   req_wdata,
  input logic          pci_valid,
  input logic          pci_err,
  input logic [2:0]    pci_cmd,
  input logic [PW-1:0] pci_addr,
  input logic [3:0]    pci_be,
  input logic          hae_wr,
  input logic [PW-1:0] hae_q,
  input logic          win_miss
);
  localparam logic [PW-1:0] KEEP = {{SH{1'b1}}, {(PW-SH){1'b0}}};

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pci_valid && !pci_err));

  // R10
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pci_valid && pci_err));

  // R9
  miss_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_miss) |=> (pci_err && !pci_valid));

  // R7
  hae_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hae_wr |=> (hae_q == (PW'($past(req_wdata)) & KEEP)));

  // R7
  hae_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && pci_cmd == 3'd2) |-> ((pci_addr & KEEP) == hae_q));

  // R8
  dense_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && pci_cmd == 3'd3) |-> (pci_be == 4'hF && pci_addr[1:0] == 2'b00));

  // R2
  io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_valid && (pci_cmd == 3'd1 || pci_cmd == 3'd4 || pci_cmd == 3'd5))
      |-> (pci_addr[PW-1:24] == '0));

  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> (pci_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF}));
endmodule

bind hpx_xlate hpx_xlate_chk #(.PW(PW), .SH(SH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_wdata (req_wdata),
  .pci_valid (pci_valid),
  .pci_err   (pci_err),
  .pci_cmd   (pci_cmd),
  .pci_addr  (pci_addr),
  .pci_be    (pci_be),
  .hae_wr    (hae_wr),
  .hae_q     (hae_q),
  .win_miss  (win_miss)
);

// File: tb/hpx_xlate_tb.sv
module hpx_xlate_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_write;
  logic [33:0] req_addr;
  logic [1:0]  req_dsize;
  logic [31:0] req_wdata, bus_rdata;
  logic        pci_valid, pci_err;
  logic [2:0]  pci_cmd;
  logic [31:0] pci_addr, pci_wdata, host_rdata;
  logic [3:0]  pci_be;

  hpx_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_dsize(req_dsize), .req_wdata(req_wdata),
    .bus_rdata(bus_rdata), .pci_valid(pci_valid), .pci_err(pci_err),
    .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_be(pci_be),
    .pci_wdata(pci_wdata), .host_rdata(host_rdata)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expectation for the response due at the next sample point
  bit          e_valid, e_err, e_isrd;
  longint unsigned e_cmd, e_addr, e_be, e_wd, e_rd;
  string       e_tag, e_atag;
  longint unsigned hae_m;

  task automatic chk(bit ok, string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(pci_valid == e_valid, e_tag, "valid", pci_valid, e_valid);
    chk(pci_err == e_err, e_tag, "err", pci_err, e_err);
    if (e_valid) begin
      chk(pci_cmd == e_cmd, "R1", "cmd", pci_cmd, e_cmd);
      chk(pci_addr == e_addr, e_atag, "addr", pci_addr, e_addr);
      chk(pci_be == e_be, "R4", "be", pci_be, e_be);
      chk(pci_wdata == e_wd, "R5", "wdata", pci_wdata, e_wd);
      if (e_isrd) chk(host_rdata == e_rd, "R6", "rdata", host_rdata, e_rd);
    end else begin
      chk(pci_cmd == 0, "R1", "cmd idle", pci_cmd, 0);
    end
  endtask

  task automatic model(bit v, bit w, longint unsigned a, int unsigned ds,
                       longint unsigned wd, longint unsigned rd);
    longint unsigned win, off, code, lane, n, lim;
    e_valid = 0; e_err = 0; e_isrd = 0; e_cmd = 0; e_addr = 0; e_be = 0;
    e_wd = 0; e_rd = 0; e_tag = "R10"; e_atag = "R2";
    if (!v) return;
    win = a / 64'd536870912;
    if (win < 12) begin
      e_err = 1; e_tag = "R9";
      return;
    end
    if (win == 12) begin
      e_tag = "R7";
      if (w) hae_m = (wd / 64'd134217728) * 64'd134217728;
      return;
    end
    if (win >= 24) begin
      e_tag = "R8";
      if (ds != 2 || (a % 4) != 0) begin e_err = 1; return; end
      e_valid = 1; e_cmd = 3; e_addr = a % 64'h1_0000_0000; e_atag = "R8";
      e_be = 15; e_wd = w ? wd : 0; e_isrd = !w; e_rd = rd;
      return;
    end
    if (win >= 16) off = a - 64'h2_0000_0000;
    else           off = a - win * 64'd536870912;
    code = (off / 8) % 4;
    lane = (off / 32) % 4;
    n = (code == 0) ? 1 : (code == 1) ? 2 : (code == 3) ? 4 : 0;
    if (n == 0)        begin e_err = 1; e_tag = "R3"; return; end
    if (lane + n > 4)  begin e_err = 1; e_tag = "R4"; return; end
    e_tag = "R1";
    e_valid = 1;
    lim = 64'd1 << (8 * n);
    e_be = ((64'd1 << n) - 1) << lane;
    e_wd = w ? ((wd % lim) << (8 * lane)) : 0;
    e_isrd = !w;
    e_rd = (rd >> (8 * lane)) % lim;
    case (win)
      13: e_cmd = 4;
      14: e_cmd = 1;
      15: e_cmd = 5;
      default: e_cmd = 2;
    endcase
    if (win >= 16) begin e_addr = off / 32 + hae_m; e_atag = "R7"; end
    else           begin e_addr = off / 32;         e_atag = "R2"; end
  endtask

  task automatic step(bit v, bit w, longint unsigned a, int unsigned ds,
                      longint unsigned wd, longint unsigned rd);
    @(negedge clk);
    compare();
    model(v, w, a, ds, wd, rd);
    req_valid = v; req_write = w; req_addr = a[33:0]; req_dsize = ds[1:0];
    req_wdata = wd[31:0]; bus_rdata = rd[31:0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=hung exp=done");
    finish_run();
  end

  initial begin
    hae_m = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_dsize = 0;
    req_wdata = 0; bus_rdata = 0;
    model(0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(pci_valid == 0 && pci_err == 0, "R10", "reset", {pci_valid, pci_err}, 0);
    rst_n = 1;

    // R7: extension write then sparse read in the very next cycle
    step(1, 1, 64'h1_8000_0000, 0, 64'hA800_1234, 0);
    step(1, 0, 64'h2_0000_0000 + (64'h123456 << 5), 0, 0, 64'h1122_3344);
    // R7: extension read has no effect, register value unchanged
    step(1, 0, 64'h1_8000_0000, 0, 0, 0);
    step(1, 0, 64'h2_0000_0000 + (64'h10 << 5) + (3 << 3), 2, 0, 64'hDEAD_BEEF);
    // R4: word at lane 3 and longword at lane 1
    step(1, 1, 64'h1_C000_0000 + (64'h3 << 5) + (1 << 3), 0, 64'hBEEF, 0);
    step(1, 1, 64'h1_C000_0000 + (64'h1 << 5) + (3 << 3), 0, 64'h1234_5678, 0);
    // R3: reserved size code 10
    step(1, 0, 64'h1_E000_0000 + (2 << 3), 0, 0, 0);
    // R5 word write at lane 2 on I/O, R2 upper bits
    step(1, 1, 64'h1_C000_0000 + (64'hABCDE6 << 5) + (1 << 3), 0, 64'hFFFF_5AA5, 0);
    // R8 dense cases
    step(1, 1, 64'h3_1234_5678, 2, 64'hCAFE_F00D, 0);
    step(1, 0, 64'h3_1234_5672, 2, 0, 0);
    step(1, 0, 64'h3_1234_5670, 1, 0, 0);
    step(1, 0, 64'h3_8000_0004, 2, 0, 64'h0BAD_C0DE);
    // R9 misses
    step(1, 0, 64'h0_1000_0000, 2, 0, 0);
    step(1, 1, 64'h1_4000_0000, 2, 0, 0);
    // R10 idle
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 64'h2_0000_0000, 0, 0, 0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned k;
      longint unsigned a, wd, rd;
      int unsigned ds;
      bit w, v;
      k  = $urandom_range(0, 9);
      w  = $urandom_range(0, 1) == 1;
      wd = $urandom;
      rd = $urandom;
      ds = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 2;
      v  = 1;
      case (k)
        0: a = longint'($urandom) & 64'h1_7FFF_FFFF;
        1: a = 64'h1_8000_0000 + (longint'($urandom) & 64'h1FFF_FFFF);
        2: a = 64'h1_A000_0000 + (longint'($urandom) & 64'h1FFF_FFFF);
        3: a = 64'h1_C000_0000 + (longint'($urandom) & 64'h1FFF_FFFF);
        4: a = 64'h1_E000_0000 + (longint'($urandom) & 64'h1FFF_FFFF);
        5, 6: a = 64'h2_0000_0000 + longint'($urandom);
        7, 8: begin
          a = 64'h3_0000_0000 + longint'($urandom);
          if ($urandom_range(0, 3) != 0) a = a & ~64'h3;
        end
        default: begin a = 0; v = 0; end
      endcase
      step(v, w, a, ds, wd, rd);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule